// File: doc/BRIEF.md
# FDDI Line State Detector

This block watches a stream of received symbol pairs, one pair per strobed cycle, and decides which line state the link is in. Long runs of identical idle, halt or quiet pairs declare the matching state; a further run of idle pairs while idle declares a super-idle state. A J followed by K pair on a line that is idle or active marks the start of a frame and puts the line in the active state. A pair that fits none of these rules drops the line into a noise state.

Each time the line enters a new state, a sticky history bit for that state is set. The bit stays set until software writes a one to it. A mask register selects which history bits raise the interrupt output. All outputs are registered and change on the clock edge that samples the pair.

Top module: `line_state_det`

## Requirements
- R1: After a synchronous reset, line_state is NOISE, frame_start is 0, hist and mask are all zero, and irq is 0.
- R2: Line state codes on line_state are NOISE=0, ACTIVE=1, IDLE=2, SUPER_IDLE=3, HALT=4, QUIET=5; history and mask bit i belongs to state code i. Symbol codes in pair_code, with the first symbol in bits 9:5: idle 11111, halt 00100, quiet 00000, J 11000, K 10001.
- R3: RUN_LEN (default 16) consecutive halt pairs declare HALT and RUN_LEN consecutive quiet pairs declare QUIET; RUN_LEN-1 pairs do not change the state.
- R4: RUN_LEN consecutive idle pairs declare IDLE; while in IDLE, SUPER_LEN (default 8) further consecutive idle pairs declare SUPER_IDLE, and SUPER_LEN-1 do not.
- R5: Any pair of a different kind restarts the consecutive-pair count; cycles with pair_vld low neither count nor break a run.
- R6: A JK pair (11000 10001) received in IDLE, SUPER_IDLE or ACTIVE moves the line to ACTIVE and raises frame_start for exactly one cycle; a JK pair in NOISE, HALT or QUIET moves the line to NOISE with frame_start low.
- R7: In ACTIVE, pairs hold the state until a halt, quiet or idle run completes, which declares that run's state. In IDLE, SUPER_IDLE, HALT or QUIET, a non-JK pair of a kind other than the one that state is built from moves the line to NOISE.
- R8: Entering a state sets its hist bit, which stays set until a write with hist_clr_we clears the bits where hist_clr_bits is 1; a set on the same edge wins over the clear.
- R9: mask is loaded from mask_bits when mask_we is high; irq is the OR over all bits of hist AND mask, updated on the same edge as hist and mask.
- R10: frame_start is only raised on the edge that samples a valid pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_vld | input | 1 | pair_code holds a received pair this cycle |
| pair_code | input | 10 | Symbol pair, first symbol in bits 9:5 |
| hist_clr_we | input | 1 | Write strobe for clearing history bits |
| hist_clr_bits | input | 6 | Ones clear the matching history bits |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_bits | input | 6 | New mask value |
| line_state | output | 3 | Current line state code |
| frame_start | output | 1 | One-cycle frame start pulse |
| hist | output | 6 | Sticky per-state entry history |
| mask | output | 6 | Current interrupt mask |
| irq | output | 1 | Interrupt, OR of hist AND mask |

## Verification
Run lengths of halt, quiet and idle pairs are swept from one pair up past the threshold, so a wrong threshold by one in either direction shows as a state that appears too early or too late; idle runs are swept further to place the super-idle boundary. Interrupted runs and runs split by invalid cycles separate a counter that restarts from one that merely pauses. JK pairs are sent from every kind of preceding state to tell frame starts from noise, and history writes are tried alone, with the mask, and on the same edge as a new entry to check that set beats clear.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int SYM_W  = 5;
  localparam int PAIR_W = 2 * SYM_W;
  localparam int NUM_LS = 6;

  localparam logic [SYM_W-1:0] SYM_IDLE  = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_HALT  = 5'b00100;
  localparam logic [SYM_W-1:0] SYM_QUIET = 5'b00000;
  localparam logic [SYM_W-1:0] SYM_J     = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K     = 5'b10001;

  typedef enum logic [2:0] {
    LS_NOISE  = 3'd0,
    LS_ACTIVE = 3'd1,
    LS_IDLE   = 3'd2,
    LS_SUPER  = 3'd3,
    LS_HALT   = 3'd4,
    LS_QUIET  = 3'd5
  } line_state_e;

  typedef enum logic [2:0] {
    PC_OTHER = 3'd0,
    PC_IDLE  = 3'd1,
    PC_HALT  = 3'd2,
    PC_QUIET = 3'd3,
    PC_JK    = 3'd4
  } pair_class_e;

  function automatic line_state_e run_state(input pair_class_e c);
    case (c)
      PC_IDLE:  return LS_IDLE;
      PC_HALT:  return LS_HALT;
      PC_QUIET: return LS_QUIET;
      default:  return LS_NOISE;
    endcase
  endfunction
endpackage

// File: rtl/lsd_classify.sv
module lsd_classify
  import lsd_pkg::*;
(
  input  logic [PAIR_W-1:0] pair,
  output pair_class_e       cls
);
  logic [SYM_W-1:0] first_sym, second_sym;
  assign first_sym  = pair[PAIR_W-1:SYM_W];
  assign second_sym = pair[SYM_W-1:0];

  always_comb begin
    cls = PC_OTHER;
    if (first_sym == SYM_J && second_sym == SYM_K)
      cls = PC_JK;
    else if (first_sym == second_sym) begin
      case (first_sym)
        SYM_IDLE:  cls = PC_IDLE;
        SYM_HALT:  cls = PC_HALT;
        SYM_QUIET: cls = PC_QUIET;
        default:   cls = PC_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/lsd_tracker.sv
module lsd_tracker
  import lsd_pkg::*;
#(
  parameter int RUN_LEN   = 16,
  parameter int SUPER_LEN = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        vld,
  input  pair_class_e cls,
  output line_state_e state_q,
  output line_state_e state_d,
  output logic        enter,
  output logic        fs_q
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(RUN_LEN);
  localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);
  localparam logic [CW-1:0] SUP_MAX  = CW'(SUPER_LEN);

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc, cnt_run;
  pair_class_e   last_q;
  logic          fs_d, run_cls, idle_fam, done, same_kind;

  assign run_cls  = (cls == PC_IDLE) || (cls == PC_HALT) || (cls == PC_QUIET);
  assign idle_fam = (state_q == LS_IDLE) || (state_q == LS_SUPER);
  assign cnt_inc  = (cnt_q == RUN_MAX) ? cnt_q : cnt_q + 1'b1;
  assign cnt_run  = !run_cls ? '0 : ((cls == last_q) ? cnt_inc : CW'(1));
  assign done     = run_cls && (cls == last_q) && (cnt_q == RUN_LAST);

  always_comb begin
    case (state_q)
      LS_IDLE, LS_SUPER: same_kind = (cls == PC_IDLE);
      LS_HALT:           same_kind = (cls == PC_HALT);
      LS_QUIET:          same_kind = (cls == PC_QUIET);
      default:           same_kind = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fs_d    = 1'b0;
    if (vld) begin
      cnt_d = cnt_run;
      if (cls == PC_JK) begin
        if (idle_fam || state_q == LS_ACTIVE) begin
          state_d = LS_ACTIVE;
          fs_d    = 1'b1;
        end else begin
          state_d = LS_NOISE;
        end
      end else if (done && !(cls == PC_IDLE && idle_fam)) begin
        state_d = run_state(cls);
        if (cls == PC_IDLE) cnt_d = '0;
      end else if (cls == PC_IDLE && state_q == LS_IDLE && cnt_run == SUP_MAX) begin
        state_d = LS_SUPER;
      end else if (state_q != LS_ACTIVE && !same_kind) begin
        state_d = LS_NOISE;
      end
    end
  end

  assign enter = vld && (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LS_NOISE;
      cnt_q   <= '0;
      last_q  <= PC_OTHER;
      fs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fs_q    <= fs_d;
      if (vld) last_q <= cls;
    end
  end
endmodule

// File: rtl/lsd_history.sv
module lsd_history
  import lsd_pkg::*;
#(
  parameter int NBITS = NUM_LS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter,
  input  line_state_e      new_state,
  input  logic             clr_we,
  input  logic [NBITS-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [NBITS-1:0] mask_bits,
  output logic [NBITS-1:0] hist_q,
  output logic [NBITS-1:0] mask_q,
  output logic             irq_q
);
  logic [NBITS-1:0] hist_d, mask_d;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic set_i, clr_i;
    assign set_i     = enter && (new_state == line_state_e'(i));
    assign clr_i     = clr_we && clr_bits[i];
    assign hist_d[i] = set_i || (hist_q[i] && !clr_i);
  end

  assign mask_d = mask_we ? mask_bits : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      mask_q <= mask_d;
      irq_q  <= |(hist_d & mask_d);
    end
  end
endmodule

// File: rtl/line_state_det.sv
module line_state_det
  import lsd_pkg::*;
#(
  parameter int RUN_LEN   = 16,
  parameter int SUPER_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pair_vld,
  input  logic [PAIR_W-1:0] pair_code,
  input  logic              hist_clr_we,
  input  logic [NUM_LS-1:0] hist_clr_bits,
  input  logic              mask_we,
  input  logic [NUM_LS-1:0] mask_bits,
  output logic [2:0]        line_state,
  output logic              frame_start,
  output logic [NUM_LS-1:0] hist,
  output logic [NUM_LS-1:0] mask,
  output logic              irq
);
  pair_class_e cls;
  line_state_e st_q, st_d;
  logic        enter;

  lsd_classify u_cls (
    .pair (pair_code),
    .cls  (cls)
  );

  lsd_tracker #(.RUN_LEN(RUN_LEN), .SUPER_LEN(SUPER_LEN)) u_trk (
    .clk     (clk),
    .rst     (rst),
    .vld     (pair_vld),
    .cls     (cls),
    .state_q (st_q),
    .state_d (st_d),
    .enter   (enter),
    .fs_q    (frame_start)
  );

  lsd_history #(.NBITS(NUM_LS)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .enter     (enter),
    .new_state (st_d),
    .clr_we    (hist_clr_we),
    .clr_bits  (hist_clr_bits),
    .mask_we   (mask_we),
    .mask_bits (mask_bits),
    .hist_q    (hist),
    .mask_q    (mask),
    .irq_q     (irq)
  );

  assign line_state = st_q;
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker
  import lsd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pair_vld,
  input logic              hist_clr_we,
  input logic [2:0]        line_state,
  input logic              frame_start,
  input logic [NUM_LS-1:0] hist,
  input logic [NUM_LS-1:0] mask,
  input logic              irq
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (line_state == 3'd0 && hist == '0 && mask == '0 && !irq && !frame_start));

  a_r10_fs_needs_pair: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $past(pair_vld));

  a_r6_fs_in_active: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_state == 3'd1);

  a_r5_hold_without_pair: assert property (@(posedge clk) disable iff (rst)
    !pair_vld |=> line_state == $past(line_state));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !hist_clr_we |=> ((hist & $past(hist)) == $past(hist)));

  a_r8_one_entry: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $onehot0(hist & ~$past(hist)));

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
    irq == |(hist & mask));
endmodule

bind line_state_det lsd_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .pair_vld    (pair_vld),
  .hist_clr_we (hist_clr_we),
  .line_state  (line_state),
  .frame_start (frame_start),
  .hist        (hist),
  .mask        (mask),
  .irq         (irq)
);

// File: tb/line_state_det_bench.sv
module line_state_det_bench;
  localparam int RUN = 16;
  localparam int SUP = 8;
  localparam logic [9:0] P_IDLE  = 10'b11111_11111;
  localparam logic [9:0] P_HALT  = 10'b00100_00100;
  localparam logic [9:0] P_QUIET = 10'b00000_00000;
  localparam logic [9:0] P_JK    = 10'b11000_10001;
  localparam logic [9:0] P_DATA  = 10'b01010_10101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pair_vld = 1'b0;
  logic [9:0] pair_code = '0;
  logic       hist_clr_we = 1'b0;
  logic [5:0] hist_clr_bits = '0;
  logic       mask_we = 1'b0;
  logic [5:0] mask_bits = '0;
  logic [2:0] line_state;
  logic       frame_start;
  logic [5:0] hist, mask;
  logic       irq;
  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  line_state_det #(.RUN_LEN(RUN), .SUPER_LEN(SUP)) u_line_state_det (
    .clk, .rst, .pair_vld, .pair_code, .hist_clr_we, .hist_clr_bits,
    .mask_we, .mask_bits, .line_state, .frame_start, .hist, .mask, .irq
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pair_vld = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic burst(input logic [9:0] p, input int n);
    if (n > 0) begin
      @(negedge clk); pair_vld = 1'b1; pair_code = p;
      repeat (n) @(negedge clk);
      pair_vld = 1'b0;
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int run_code(input logic [9:0] p);
    if (p == P_HALT) return 4;
    if (p == P_QUIET) return 5;
    return 2;
  endfunction

  initial begin
    logic [9:0] kinds [3];
    kinds[0] = P_HALT; kinds[1] = P_QUIET; kinds[2] = P_IDLE;

    do_reset();
    check("R1 state", line_state, 0);
    check("R1 hist", hist, 0);
    check("R1 mask", mask, 0);
    check("R1 irq", irq, 0);
    check("R1 frame_start", frame_start, 0);

    // R3 / R4: run length sweep for every run kind
    for (int k = 0; k < 3; k++) begin
      for (int n = 1; n <= RUN + 1; n++) begin
        do_reset();
        burst(kinds[k], n);
        check(k == 2 ? "R4 idle run" : "R3 halt/quiet run", line_state,
              (n >= RUN) ? run_code(kinds[k]) : 0);
      end
    end

    // R4: super idle sweep after idle is declared
    for (int m = 0; m <= SUP + 2; m++) begin
      do_reset();
      burst(P_IDLE, RUN + m);
      check("R4 super idle", line_state, (m >= SUP) ? 3 : 2);
    end

    // R5: interrupted run restarts; invalid cycles do not break
    do_reset();
    burst(P_HALT, RUN - 1); burst(P_DATA, 1); burst(P_HALT, RUN - 1);
    check("R5 restart after other pair", line_state, 0);
    burst(P_HALT, 1);
    check("R5 full fresh run", line_state, 4);
    do_reset();
    burst(P_QUIET, RUN / 2); gap(3); burst(P_QUIET, RUN / 2);
    check("R5 gaps keep run", line_state, 5);
    do_reset();
    burst(P_HALT, RUN - 1); burst(P_QUIET, 1); burst(P_HALT, 1);
    check("R5 other run kind restarts", line_state, 0);

    // R6: JK handling
    do_reset();
    burst(P_JK, 1);
    check("R6 JK in noise state", line_state, 0);
    check("R6 JK in noise no start", frame_start, 0);
    burst(P_IDLE, RUN); burst(P_JK, 1);
    check("R6 JK from idle state", line_state, 1);
    check("R6 JK from idle start", frame_start, 1);
    gap(1);
    check("R6 start one cycle", frame_start, 0);
    burst(P_DATA, 3);
    check("R7 data keeps active", line_state, 1);
    check("R10 no start on data", frame_start, 0);
    burst(P_JK, 1);
    check("R6 JK in active start", frame_start, 1);
    burst(P_IDLE, RUN - 1);
    check("R7 short idle keeps active", line_state, 1);
    burst(P_IDLE, 1);
    check("R7 idle run leaves active", line_state, 2);
    burst(P_JK, 1); burst(P_HALT, RUN);
    check("R7 halt run leaves active", line_state, 4);
    burst(P_JK, 1);
    check("R6 JK in halt state", line_state, 0);
    check("R6 JK in halt no start", frame_start, 0);
    do_reset();
    burst(P_IDLE, RUN + SUP); burst(P_JK, 1);
    check("R6 JK from super idle", line_state, 1);
    check("R6 JK from super idle start", frame_start, 1);

    // R7: mismatching pairs drop to noise
    do_reset();
    burst(P_IDLE, RUN); burst(P_HALT, 1);
    check("R7 halt pair in idle", line_state, 0);
    do_reset();
    burst(P_QUIET, RUN); burst(P_IDLE, 1);
    check("R7 idle pair in quiet", line_state, 0);

    // R8 / R9: history, mask, interrupt
    do_reset();
    burst(P_IDLE, RUN);
    check("R8 idle entry bit", hist, 6'b000100);
    burst(P_DATA, 1);
    check("R8 sticky plus noise bit", hist, 6'b000101);
    check("R9 irq masked off", irq, 0);
    @(negedge clk); mask_we = 1'b1; mask_bits = 6'b000100;
    @(negedge clk); mask_we = 1'b0;
    check("R9 mask readback", mask, 6'b000100);
    check("R9 irq on mask", irq, 1);
    @(negedge clk); hist_clr_we = 1'b1; hist_clr_bits = 6'b000100;
    @(negedge clk); hist_clr_we = 1'b0;
    check("R8 clear one bit", hist, 6'b000001);
    check("R9 irq after clear", irq, 0);
    do_reset();
    burst(P_IDLE, RUN - 1);
    @(negedge clk); pair_vld = 1'b1; pair_code = P_IDLE;
    hist_clr_we = 1'b1; hist_clr_bits = 6'b000100;
    @(negedge clk); pair_vld = 1'b0; hist_clr_we = 1'b0;
    check("R8 set wins over clear", hist, 6'b000100);
    check("R2 idle code", line_state, 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule